// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second ALU operand in one combinational pass. It takes a 32-bit register value and shifts it by an amount. The amount comes either from a 5-bit field in the instruction or from the low byte of another register. The block can also produce a constant instead: an 8-bit value rotated right by twice a 4-bit field. Besides the operand it produces the shifter carry-out, which the flag logic uses when no arithmetic carry applies.

The shift is built as a cascade of multiplexer stages, one stage per power of two. A left shift is done on a bit-reversed copy of the word, so the same right-rotating cascade serves all four shift kinds and the immediate path. After the cascade, a threshold mask clears or sign-fills the bits that have wrapped around. No register sits on the path, so the result settles in the same cycle as the inputs.

Top module: `shf_operand2`

## Requirements
- R1: With `kind_i` = 0 (logical left) and an amount n of 1 to 31, `opnd_o` equals the operand shifted left by n with zeros entering, and `carry_o` equals operand bit 32-n.
- R2: With `kind_i` = 1 (logical right) and an amount n of 1 to 31, `opnd_o` is the operand shifted right by n with zeros entering, and `carry_o` equals operand bit n-1.
- R3: With `kind_i` = 2 (arithmetic right) and an amount n of 1 to 31, the vacated upper bits take the value of operand bit 31, and `carry_o` equals operand bit n-1.
- R4: With `kind_i` = 3 (rotate right) and a nonzero amount n, `opnd_o` is the operand rotated right by n mod 32, and `carry_o` equals bit 31 of that result.
- R5: An amount of zero from either source passes the operand through unchanged and sets `carry_o` to `carry_i`.
- R6: With `amt_from_reg_i` = 1 the amount is `amt_reg_i` (0 to 255) and `amt_imm_i` is ignored. With `amt_from_reg_i` = 0 the amount is `amt_imm_i` (0 to 31) and `amt_reg_i` is ignored.
- R7: A register amount of exactly 32 gives 0 for both logical shifts. The carry is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R8: A register amount above 32 gives 0 with a carry of 0 for both logical shifts. For an arithmetic shift, any amount of 32 or more fills every bit of `opnd_o` and the carry with operand bit 31.
- R9: With `imm_mode_i` = 1, `opnd_o` is `imm_val_i`, zero-extended, rotated right by 2 x `imm_rot_i`. `carry_o` is bit 31 of that result when `imm_rot_i` is nonzero and `carry_i` when it is zero. `opnd_i`, `kind_i` and both amount inputs have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register value to shift |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg_i | input | 1 | 1 takes the amount from `amt_reg_i`, 0 from `amt_imm_i` |
| amt_imm_i | input | 5 | Instruction-field shift amount |
| amt_reg_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| imm_mode_i | input | 1 | 1 selects the rotated-constant path |
| imm_val_i | input | 8 | 8-bit constant |
| imm_rot_i | input | 4 | Rotate field; the rotation is twice this value |
| opnd_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so any fault shows at the outputs as soon as the inputs settle. A broken multiplexer stage corrupts only those amounts that have that stage's bit set. The bench therefore walks every amount from 0 to 63 for each shift kind, so that every stage is used both alone and combined with the others. A wrong threshold mask shows up only at amounts of 32 and above, or next to them. The zero and 32 cases and the ignored inputs are driven on purpose. Carry faults are visible only through `carry_o`, so every check compares `carry_o` as well as `opnd_o`.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL = 2'd0,
    SHF_LSR = 2'd1,
    SHF_ASR = 2'd2,
    SHF_ROR = 2'd3
  } shf_kind_e;
endpackage

// File: rtl/shf_src_mux.sv
module shf_src_mux
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]    opnd_i,
  input  shf_kind_e            kind_i,
  input  logic                 amt_from_reg_i,
  input  logic [IMM_AMT_W-1:0] amt_imm_i,
  input  logic [REG_AMT_W-1:0] amt_reg_i,
  input  logic                 imm_mode_i,
  input  logic [IMM_W-1:0]     imm_val_i,
  input  logic [ROT_W-1:0]     imm_rot_i,
  output logic [DATA_W-1:0]    src_o,
  output logic [DATA_W-1:0]    work_o,
  output logic [REG_AMT_W-1:0] amt_o,
  output shf_kind_e            kind_o
);
  localparam int IMM_PAD = DATA_W - IMM_W;
  localparam int FLD_PAD = REG_AMT_W - IMM_AMT_W;
  localparam int ROT_PAD = REG_AMT_W - ROT_W - 1;

  logic [DATA_W-1:0] src_rev;

  assign src_o  = imm_mode_i ? {{IMM_PAD{1'b0}}, imm_val_i} : opnd_i;
  assign kind_o = imm_mode_i ? SHF_ROR : kind_i;

  always_comb begin
    if (imm_mode_i)          amt_o = {{ROT_PAD{1'b0}}, imm_rot_i, 1'b0};
    else if (amt_from_reg_i) amt_o = amt_reg_i;
    else                     amt_o = {{FLD_PAD{1'b0}}, amt_imm_i};
  end

  // left shifts run through the right rotator on a mirrored word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign src_rev[i] = src_o[DATA_W-1-i];
  end

  assign work_o = (kind_o == SHF_LSL) ? src_rev : src_o;
endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LOG_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stage [LOG_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k]
      ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
      : stage[k];
  end

  assign data_o = stage[LOG_W];

  always_comb begin
    if (!$isunknown({data_i, amt_i})) begin
      // R4
      rot_popcount_chk: assert ($countones(data_o) == $countones(data_i))
        else $error("rotator changed bit count");
    end
  end
endmodule

// File: rtl/shf_fill.sv
module shf_fill
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]    src_i,
  input  logic [DATA_W-1:0]    rot_i,
  input  logic [REG_AMT_W-1:0] amt_i,
  input  shf_kind_e            kind_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    opnd_o,
  output logic                 carry_o
);
  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(DATA_W);

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] shaped;
  logic              sign;
  logic              amt_zero;
  logic              amt_over;

  // bit i survives when it did not wrap: i + n < W
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep_mask[i] = (32'(amt_i) + 32'(i)) < 32'(DATA_W);
  end

  assign sign     = src_i[DATA_W-1];
  assign amt_zero = (amt_i == '0);
  assign amt_over = (amt_i > FULL);

  always_comb begin
    shaped  = rot_i;
    carry_o = rot_i[DATA_W-1];
    unique case (kind_i)
      SHF_LSL, SHF_LSR: begin
        shaped = rot_i & keep_mask;
        if (amt_over) carry_o = 1'b0;
      end
      SHF_ASR: begin
        shaped = (rot_i & keep_mask) | (~keep_mask & {DATA_W{sign}});
        if (amt_over) carry_o = sign;
      end
      default: ;
    endcase
    opnd_o = shaped;
    if (kind_i == SHF_LSL) begin
      for (int i = 0; i < DATA_W; i++) opnd_o[i] = shaped[DATA_W-1-i];
    end
    if (amt_zero) begin
      opnd_o  = src_i;
      carry_o = carry_i;
    end
  end

  always_comb begin
    if (!$isunknown({src_i, amt_i, kind_i, carry_i})) begin
      // R7
      logic_flush_chk: assert (!((kind_i == SHF_LSL || kind_i == SHF_LSR) && amt_i >= FULL)
                               || opnd_o == '0)
        else $error("logical shift by full width not zero");
      // R8
      sign_flood_chk: assert (!(kind_i == SHF_ASR && amt_i >= FULL)
                              || (opnd_o == {DATA_W{sign}} && carry_o == sign))
        else $error("arithmetic shift by full width not sign filled");
    end
  end
endmodule

// File: rtl/shf_operand2.sv
module shf_operand2
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  localparam int LOG_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]    opnd_i,
  input  logic [1:0]           kind_i,
  input  logic                 amt_from_reg_i,
  input  logic [IMM_AMT_W-1:0] amt_imm_i,
  input  logic [REG_AMT_W-1:0] amt_reg_i,
  input  logic                 carry_i,
  input  logic                 imm_mode_i,
  input  logic [IMM_W-1:0]     imm_val_i,
  input  logic [ROT_W-1:0]     imm_rot_i,
  output logic [DATA_W-1:0]    opnd_o,
  output logic                 carry_o
);
  logic [DATA_W-1:0]    src;
  logic [DATA_W-1:0]    work;
  logic [DATA_W-1:0]    rotated;
  logic [REG_AMT_W-1:0] amt;
  shf_kind_e            kind_eff;

  shf_src_mux #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W),
    .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W)
  ) u_src (
    .opnd_i        (opnd_i),
    .kind_i        (shf_kind_e'(kind_i)),
    .amt_from_reg_i(amt_from_reg_i),
    .amt_imm_i     (amt_imm_i),
    .amt_reg_i     (amt_reg_i),
    .imm_mode_i    (imm_mode_i),
    .imm_val_i     (imm_val_i),
    .imm_rot_i     (imm_rot_i),
    .src_o         (src),
    .work_o        (work),
    .amt_o         (amt),
    .kind_o        (kind_eff)
  );

  shf_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i(work),
    .amt_i (amt[LOG_W-1:0]),
    .data_o(rotated)
  );

  shf_fill #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_fill (
    .src_i  (src),
    .rot_i  (rotated),
    .amt_i  (amt),
    .kind_i (kind_eff),
    .carry_i(carry_i),
    .opnd_o (opnd_o),
    .carry_o(carry_o)
  );

  always_comb begin
    if (!$isunknown({opnd_i, kind_i, amt_from_reg_i, amt_imm_i, amt_reg_i,
                     carry_i, imm_mode_i, imm_val_i, imm_rot_i})) begin
      // R5
      zero_pass_chk: assert (imm_mode_i
                             || (amt_from_reg_i ? amt_reg_i != '0 : amt_imm_i != '0)
                             || (opnd_o == opnd_i && carry_o == carry_i))
        else $error("zero amount altered operand");
      // R9
      imm_bits_chk: assert (!imm_mode_i || $countones(opnd_o) == $countones(imm_val_i))
        else $error("immediate path changed bit count");
      // R9
      imm_carry_chk: assert (!imm_mode_i
                             || carry_o == ((imm_rot_i == '0) ? carry_i : opnd_o[DATA_W-1]))
        else $error("immediate carry wrong");
      // R4
      ror_carry_chk: assert (imm_mode_i || kind_i != 2'd3
                             || (amt_from_reg_i ? amt_reg_i == '0 : amt_imm_i == '0)
                             || carry_o == opnd_o[DATA_W-1])
        else $error("rotate carry not result msb");
    end
  end
endmodule

// File: tb/shf_operand2_tb.sv
module shf_operand2_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [1:0]  kind_i = '0;
  logic        amt_from_reg_i = 1'b0;
  logic [4:0]  amt_imm_i = '0;
  logic [7:0]  amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic        imm_mode_i = 1'b0;
  logic [7:0]  imm_val_i = '0;
  logic [3:0]  imm_rot_i = '0;
  logic [31:0] opnd_o;
  logic        carry_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  shf_operand2 u_dut (
    .opnd_i(opnd_i), .kind_i(kind_i), .amt_from_reg_i(amt_from_reg_i),
    .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i), .carry_i(carry_i),
    .imm_mode_i(imm_mode_i), .imm_val_i(imm_val_i), .imm_rot_i(imm_rot_i),
    .opnd_o(opnd_o), .carry_o(carry_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // one bit per step, carry is the bit that falls off
  function automatic logic [32:0] model(input logic [31:0] op, input int kind,
                                        input int n, input logic cin);
    logic [31:0] r = op;
    logic        c = cin;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  task automatic compare(input string tag, input logic [32:0] exp);
    checks++;
    if ({carry_o, opnd_o} !== exp) begin
      fails++;
      $display("FAIL %s: actual opnd=%h carry=%b expected opnd=%h carry=%b",
               tag, opnd_o, carry_o, exp[31:0], exp[32]);
    end
  endtask

  task automatic shift_vec(input string tag, input logic [31:0] op, input int kind,
                           input bit from_reg, input int amt, input logic cin);
    @(posedge clk);
    imm_mode_i     = 1'b0;
    opnd_i         = op;
    kind_i         = 2'(kind);
    amt_from_reg_i = from_reg;
    carry_i        = cin;
    if (from_reg) begin amt_reg_i = 8'(amt); amt_imm_i = 5'(~amt); end
    else          begin amt_imm_i = 5'(amt); amt_reg_i = 8'(~amt); end
    @(negedge clk);
    compare(tag, model(op, kind, amt, cin));
  endtask

  task automatic imm_vec(input string tag, input logic [7:0] v, input int rot,
                         input logic cin, input logic [31:0] junk);
    @(posedge clk);
    imm_mode_i     = 1'b1;
    imm_val_i      = v;
    imm_rot_i      = 4'(rot);
    carry_i        = cin;
    opnd_i         = junk;
    kind_i         = junk[1:0];
    amt_from_reg_i = junk[2];
    amt_imm_i      = junk[7:3];
    amt_reg_i      = junk[15:8];
    @(negedge clk);
    compare(tag, model({24'b0, v}, 3, 2 * rot, cin));
  endtask

  initial begin
    string tags [4] = '{"R1", "R2", "R3", "R4"};
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R5 reset-time inputs: zero amount passes zero operand
    @(negedge clk);
    compare("R5", 33'd0);

    // R1 operand LSL 7
    shift_vec("R1", 32'h0000_0003, 0, 1'b0, 7, 1'b0);
    shift_vec("R1", 32'h8000_0001, 0, 1'b0, 1, 1'b0);
    shift_vec("R2", 32'h8000_0001, 1, 1'b0, 1, 1'b0);
    shift_vec("R3", 32'h8000_0000, 2, 1'b0, 31, 1'b0);
    shift_vec("R4", 32'h1234_5678, 3, 1'b0, 8, 1'b0);

    // R5 zero amount from both sources, both carry values
    for (int k = 0; k < 4; k++) begin
      shift_vec("R5", 32'hDEAD_BEEF, k, 1'b0, 0, 1'b1);
      shift_vec("R5", 32'hDEAD_BEEF, k, 1'b1, 0, 1'b0);
    end

    // R7 exactly 32
    shift_vec("R7", 32'h8000_0001, 0, 1'b1, 32, 1'b0);
    shift_vec("R7", 32'h8000_0001, 1, 1'b1, 32, 1'b0);
    shift_vec("R7", 32'h7FFF_FFFE, 0, 1'b1, 32, 1'b1);
    // R8 above 32 and ASR flood
    shift_vec("R8", 32'hFFFF_FFFF, 0, 1'b1, 33, 1'b1);
    shift_vec("R8", 32'hFFFF_FFFF, 1, 1'b1, 200, 1'b1);
    shift_vec("R8", 32'h8000_0000, 2, 1'b1, 32, 1'b0);
    shift_vec("R8", 32'h7FFF_FFFF, 2, 1'b1, 255, 1'b1);
    // R4 rotate past word size
    shift_vec("R4", 32'h8765_4321, 3, 1'b1, 32, 1'b0);
    shift_vec("R4", 32'h8765_4321, 3, 1'b1, 36, 1'b0);

    // R6 every register amount 0..63 per kind, opposite source holds garbage
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 64; n++)
        shift_vec(n == 0 ? "R5" : (n >= 32 ? (k == 3 ? "R4" : "R8") : tags[k]),
                  32'hA5C3_0F96 ^ (32'(n) << 11), k, 1'b1, n, n[0]);
    // R6 every field amount
    for (int k = 0; k < 4; k++)
      for (int n = 1; n < 32; n++)
        shift_vec("R6", 32'h9E37_79B9 * 32'(n + 1), k, 1'b0, n, 1'b1);

    // R9 rotated constants, other inputs garbage
    imm_vec("R9", 8'hFF, 0, 1'b1, 32'hFFFF_FFFF);
    imm_vec("R9", 8'h4E, 0, 1'b0, 32'h1234_5678);
    imm_vec("R9", 8'h01, 1, 1'b1, 32'h0);
    imm_vec("R9", 8'h02, 1, 1'b0, 32'hFFFF_FFFF);
    for (int r = 0; r < 16; r++) begin
      imm_vec("R9", 8'h81, r, r[0], 32'hCAFE_0000 | 32'(r));
      imm_vec("R9", 8'h3C, r, ~r[0], 32'h0F0F_F0F0 ^ 32'(r));
    end

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      int k = int'($urandom_range(0, 3));
      int n = int'($urandom_range(1, 31));
      shift_vec(tags[k], $urandom, k, 1'b0, n, 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule